// File: doc/BRIEF.md
# Real-Time Clock with Digital Rate Trim

This block keeps time of day in three BCD counters: seconds, minutes and hours. A prescaler divides the 32.768 kHz tick clock by 2^DIV_W and produces one pulse per second. That pulse advances the counters. Software controls the block through a small register port. It can start and stop counting, read and preset any counter, and choose 24-hour or 12-hour display. The 12-hour display uses a separate PM indicator. Each time the seconds counter rolls over into the minutes counter, a sticky event flag is raised.

Crystal frequency error is corrected by rate regulation. A write to the trim register can also fire a regulation. The written 6-bit code selects a signed correction of N ticks. For a positive N, the prescaler moves two states per clock for N clocks, so the current second ends early. For a negative N, the prescaler holds for N clocks, so the current second ends late. The adjustment runs inside a busy window of BUSY_TICKS clocks. Any trigger that arrives while the window is open is dropped.

The default window is 544 ticks, about 16.6 ms. BUSY_TICKS must be at least 32, so that the largest correction fits inside the window. It must also be below 2^DIV_W.

Top module: `rtc_trim_top`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. When seconds advance from 59, they become 00 and minutes advance. When minutes advance from 59, they become 00 and hours advance.
- R2: While the run bit (CTRL bit 0) is 0, the prescaler and all counters hold their values and no second pulse occurs. Setting the bit again resumes counting from the held values.
- R3: A write to CTRL with bit 0 set zeroes the prescaler. The first second pulse then follows exactly 2^DIV_W clocks after the write edge.
- R4: With CTRL bit 1 at 0 (24-hour mode), hours count from 00 to 23. Advancing from 23 gives 00.
- R5: With CTRL bit 1 at 1 (12-hour mode), hours count 12, 01 … 11. Advancing from 11 gives 12 and toggles the PM bit (HOUR bit 7). Advancing from 12 gives 01.
- R6: The trim code c (TRIM bits 5:0) means a correction of +c ticks when c is 0 to 32, and c−64 ticks when c is 33 to 63. Code 0 gives no change.
- R7: After an accepted trigger, the second in progress is shortened by N clocks for a positive correction N. It is lengthened by |N| clocks for a negative one.
- R8: An accepted trigger opens a busy window of BUSY_TICKS clocks. During the window, reg_busy and CTRL bit 3 read 1. A trigger that arrives inside the window has no effect on timing, but its code is still stored.
- R9: tick_1hz is a one-clock pulse once per prescaler wrap, and only while running. With no trim active, consecutive pulses are 2^DIV_W clocks apart.
- R10: The event flag is set when seconds roll over into minutes. It drives irq and reads as CTRL bit 2. Writing 1 to CTRL bit 2 clears it. A set in the same cycle takes priority over the clear.
- R11: A write to SEC, MIN or HOUR in the cycle where a second advance would take place stores the written value and drops that advance.
- R12: Register map: address 0 CTRL, 1 SEC (bits 6:0), 2 MIN (bits 6:0), 3 HOUR (bits 5:0 BCD, bit 7 PM), 4 TRIM (bits 5:0). Writing TRIM with bit 7 set fires a regulation using the written code. Unmapped addresses read 0.
- R13: After reset, every register reads 0, and tick_1hz, irq and reg_busy are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| tick_1hz | output | 1 | One-clock pulse per second |
| irq | output | 1 | Seconds-rollover event flag |
| reg_busy | output | 1 | Regulation window open |

## Verification
The bench builds the block with DIV_W = 7 and BUSY_TICKS = 40. With these values a second lasts 128 clocks and the busy window fits inside one second. Every trim code, including +32 and −31, therefore shows up as a single changed interval between second pulses. Minute rollover, hour rollover and both 12-hour transitions are reached within a few thousand clocks. A behavioural model compares the pulse, flag and busy outputs on every clock. It also supplies the expected register values for reads.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL = 3'd0,
        ADDR_SEC  = 3'd1,
        ADDR_MIN  = 3'd2,
        ADDR_HOUR = 3'd3,
        ADDR_TRIM = 3'd4
    } reg_addr_e;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_H12  = 1;
    localparam int CTRL_FLAG = 2;
    localparam int CTRL_BUSY = 3;
    localparam int HOUR_PM   = 7;
    localparam int TRIM_GO   = 7;
    localparam int TRIM_W    = 6;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       pm;
    } clock_t;

    // BCD increment of a two-digit value
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // codes 1..32 are positive corrections
    function automatic logic trim_positive(input logic [TRIM_W-1:0] c);
        return (c != '0) && (c <= TRIM_W'(32));
    endfunction

    function automatic logic [TRIM_W-1:0] trim_magnitude(input logic [TRIM_W-1:0] c);
        if (c <= TRIM_W'(32)) return c;
        else                  return TRIM_W'(0) - c;
    endfunction

endpackage

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler #(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic skip_i,
    input  logic hold_i,
    output logic tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             tick;
    } st_t;

    st_t            st_d, st_q;
    logic [DIV_W:0] step;
    logic [DIV_W:0] sum;

    always_comb begin
        st_d = st_q;
        if (hold_i)      step = '0;
        else if (skip_i) step = (DIV_W+1)'(2);
        else             step = (DIV_W+1)'(1);
        sum = {1'b0, st_q.div} + step;
        if (restart_i) begin
            st_d.div  = '0;
            st_d.tick = 1'b0;
        end else if (run_i) begin
            st_d.div  = sum[DIV_W-1:0];
            st_d.tick = sum[DIV_W];
        end else begin
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !restart_i |=> $stable(st_q.div)); // R2
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> $past(run_i)); // R9
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.div == '0) && !st_q.tick); // R3
    AST_HOLD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && hold_i && !restart_i |=> $stable(st_q.div) && !st_q.tick); // R7

endmodule

// File: rtl/rtc_trim_regulator.sv
module rtc_trim_regulator
    import rtc_trim_pkg::*;
#(
    parameter int BUSY_TICKS = 544
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic              skip_o,
    output logic              hold_o,
    output logic              busy_o
);

    localparam int BUSY_W = $clog2(BUSY_TICKS + 1);

    typedef struct packed {
        logic [BUSY_W-1:0] busy;
        logic [TRIM_W-1:0] adj;
        logic              pos;
    } st_t;

    st_t  st_d, st_q;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = trig_i && (st_q.busy == '0);
        if (accept) begin
            st_d.busy = BUSY_W'(BUSY_TICKS);
            st_d.adj  = trim_magnitude(trim_i);
            st_d.pos  = trim_positive(trim_i);
        end else begin
            if (st_q.busy != '0) st_d.busy = st_q.busy - BUSY_W'(1);
            if (st_q.adj != '0)  st_d.adj  = st_q.adj - TRIM_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign skip_o = (st_q.adj != '0) &&  st_q.pos;
    assign hold_o = (st_q.adj != '0) && !st_q.pos;
    assign busy_o = (st_q.busy != '0);

    AST_ADJ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.adj != '0) |-> (st_q.busy != '0)); // R8
    AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i && (st_q.busy != '0) |=> st_q.busy == $past(st_q.busy) - BUSY_W'(1)); // R8
    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i && (st_q.busy == '0) |=> st_q.busy == BUSY_W'(BUSY_TICKS)); // R8
    AST_SKIP_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_o && hold_o)); // R7

endmodule

// File: rtl/rtc_trim_timekeeper.sv
module rtc_trim_timekeeper
    import rtc_trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       h12_i,
    input  logic       wr_sec_i,
    input  logic       wr_min_i,
    input  logic       wr_hour_i,
    input  logic [7:0] wdata_i,
    output clock_t     time_o,
    output logic       wrap_o
);

    clock_t     st_d, st_q;
    logic       wr_any;
    logic       step;
    logic [7:0] sec_n, min_n, hour_n;

    always_comb begin
        st_d   = st_q;
        wr_any = wr_sec_i || wr_min_i || wr_hour_i;
        step   = adv_i && !wr_any;
        sec_n  = bcd_inc({1'b0, st_q.sec});
        min_n  = bcd_inc({1'b0, st_q.min});
        hour_n = bcd_inc({2'b00, st_q.hour});
        wrap_o = step && (st_q.sec == 7'h59);
        if (step) begin
            if (st_q.sec == 7'h59) begin
                st_d.sec = '0;
                if (st_q.min == 7'h59) begin
                    st_d.min = '0;
                    if (h12_i) begin
                        if (st_q.hour == 6'h11) begin
                            st_d.hour = 6'h12;
                            st_d.pm   = !st_q.pm;
                        end else if (st_q.hour == 6'h12) begin
                            st_d.hour = 6'h01;
                        end else begin
                            st_d.hour = hour_n[5:0];
                        end
                    end else begin
                        if (st_q.hour == 6'h23) st_d.hour = '0;
                        else                    st_d.hour = hour_n[5:0];
                    end
                end else begin
                    st_d.min = min_n[6:0];
                end
            end else begin
                st_d.sec = sec_n[6:0];
            end
        end
        if (wr_sec_i) st_d.sec = wdata_i[6:0];
        if (wr_min_i) st_d.min = wdata_i[6:0];
        if (wr_hour_i) begin
            st_d.hour = wdata_i[5:0];
            st_d.pm   = wdata_i[HOUR_PM];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o = st_q;

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !wr_any && (st_q.sec == 7'h59) |=> (st_q.sec == '0)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i && !wr_any |=> $stable(st_q)); // R2
    AST_H24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !h12_i && (st_q.sec == 7'h59) && (st_q.min == 7'h59) && (st_q.hour == 6'h23)
        |=> (st_q.hour == '0)); // R4
    AST_H12_PM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step && h12_i && (st_q.sec == 7'h59) && (st_q.min == 7'h59) && (st_q.hour == 6'h11)
        |=> (st_q.pm != $past(st_q.pm))); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec_i |=> (st_q.sec == $past(wdata_i[6:0]))); // R11

endmodule

// File: rtl/rtc_trim_top.sv
module rtc_trim_top
    import rtc_trim_pkg::*;
#(
    parameter int DIV_W      = 15,
    parameter int BUSY_TICKS = 544
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       tick_1hz,
    output logic       irq,
    output logic       reg_busy
);

    typedef struct packed {
        logic              run;
        logic              h12;
        logic              flag;
        logic [TRIM_W-1:0] trim;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    logic   wr_ctrl, wr_sec, wr_min, wr_hour, wr_trim;
    logic   restart, trig;
    logic   skip, hold, busy, tick, wrap;
    clock_t now;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_sec  = bus_wr && (bus_addr == ADDR_SEC);
    assign wr_min  = bus_wr && (bus_addr == ADDR_MIN);
    assign wr_hour = bus_wr && (bus_addr == ADDR_HOUR);
    assign wr_trim = bus_wr && (bus_addr == ADDR_TRIM);
    assign restart = wr_ctrl && bus_wdata[CTRL_RUN];
    assign trig    = wr_trim && bus_wdata[TRIM_GO];

    rtc_trim_regulator #(.BUSY_TICKS(BUSY_TICKS)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig),
        .trim_i (bus_wdata[TRIM_W-1:0]),
        .skip_o (skip),
        .hold_o (hold),
        .busy_o (busy)
    );

    rtc_trim_prescaler #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctl_q.run),
        .restart_i (restart),
        .skip_i    (skip),
        .hold_i    (hold),
        .tick_o    (tick)
    );

    rtc_trim_timekeeper u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (tick),
        .h12_i     (ctl_q.h12),
        .wr_sec_i  (wr_sec),
        .wr_min_i  (wr_min),
        .wr_hour_i (wr_hour),
        .wdata_i   (bus_wdata),
        .time_o    (now),
        .wrap_o    (wrap)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.run = bus_wdata[CTRL_RUN];
            ctl_d.h12 = bus_wdata[CTRL_H12];
            if (bus_wdata[CTRL_FLAG]) ctl_d.flag = 1'b0;
        end
        if (wrap)    ctl_d.flag = 1'b1;
        if (wr_trim) ctl_d.trim = bus_wdata[TRIM_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {4'b0000, busy, ctl_q.flag, ctl_q.h12, ctl_q.run};
            ADDR_SEC:  bus_rdata = {1'b0, now.sec};
            ADDR_MIN:  bus_rdata = {1'b0, now.min};
            ADDR_HOUR: bus_rdata = {now.pm, 1'b0, now.hour};
            ADDR_TRIM: bus_rdata = {2'b00, ctl_q.trim};
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign tick_1hz = tick;
    assign irq      = ctl_q.flag;
    assign reg_busy = busy;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> irq); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && bus_wdata[CTRL_FLAG] && !wrap |=> !irq); // R10
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |=> !tick_1hz); // R9

endmodule

// File: tb/rtc_trim_top_test.sv
`timescale 1ns/1ps
module rtc_trim_top_test;
    localparam int DIV_W = 7;
    localparam int BUSY  = 40;
    localparam int PER   = 1 << DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_1hz, irq, reg_busy;

    int checks = 0, errors = 0;
    int cyc = 0, tick_at = 0, tick_iv = 0;
    bit done = 0;

    int m_div, m_tick, m_busy, m_adj, m_pos, m_run, m_h12, m_flag, m_trim;
    int m_sec, m_min, m_hr, m_pm;

    rtc_trim_top #(.DIV_W(DIV_W), .BUSY_TICKS(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1hz(tick_1hz),
        .irq(irq), .reg_busy(reg_busy)
    );

    always #2.5 clk = ~clk;

    function automatic int b2d(int v); return (v >> 4) * 10 + (v & 15); endfunction
    function automatic int d2b(int d); return ((d / 10) << 4) | (d % 10); endfunction
    function automatic int corr(int c); return (c <= 32) ? c : c - 64; endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model_step();
        bit wc = bus_wr && bus_addr == 3'd0;
        bit ws = bus_wr && bus_addr == 3'd1;
        bit wm = bus_wr && bus_addr == 3'd2;
        bit wh = bus_wr && bus_addr == 3'd3;
        bit wt = bus_wr && bus_addr == 3'd4;
        int n_div = m_div, n_tick = 0, n_busy = m_busy, n_adj = m_adj, n_pos = m_pos;
        int n_sec = m_sec, n_min = m_min, n_hr = m_hr, n_pm = m_pm;
        int n_run = m_run, n_h12 = m_h12, n_flag = m_flag, n_trim = m_trim;
        bit wrap = 0;
        if (wt && bus_wdata[7] && m_busy == 0) begin
            int c = corr(int'(bus_wdata[5:0]));
            n_busy = BUSY;
            n_adj = (c < 0) ? -c : c;
            n_pos = (c > 0);
        end else begin
            if (m_busy > 0) n_busy--;
            if (m_adj > 0) n_adj--;
        end
        if (wc && bus_wdata[0]) n_div = 0;
        else if (m_run != 0) begin
            int st = (m_adj > 0) ? (m_pos != 0 ? 2 : 0) : 1;
            n_div = m_div + st;
            if (n_div >= PER) begin n_div -= PER; n_tick = 1; end
        end
        if (m_tick != 0 && !(ws || wm || wh)) begin
            int d = b2d(m_sec) + 1;
            if (d == 60) begin
                n_sec = 0; wrap = 1;
                d = b2d(m_min) + 1;
                if (d == 60) begin
                    n_min = 0;
                    d = b2d(m_hr);
                    if (m_h12 != 0) begin
                        if (d == 11) begin d = 12; n_pm = 1 - m_pm; end
                        else if (d == 12) d = 1;
                        else d++;
                    end else d = (d == 23) ? 0 : d + 1;
                    n_hr = d2b(d);
                end else n_min = d2b(d);
            end else n_sec = d2b(d);
        end
        if (ws) n_sec = bus_wdata[6:0];
        if (wm) n_min = bus_wdata[6:0];
        if (wh) begin n_hr = bus_wdata[5:0]; n_pm = bus_wdata[7]; end
        if (wc) begin
            n_run = bus_wdata[0]; n_h12 = bus_wdata[1];
            if (bus_wdata[2]) n_flag = 0;
        end
        if (wrap) n_flag = 1;
        if (wt) n_trim = bus_wdata[5:0];
        m_div = n_div; m_tick = n_tick; m_busy = n_busy; m_adj = n_adj; m_pos = n_pos;
        m_sec = n_sec; m_min = n_min; m_hr = n_hr; m_pm = n_pm;
        m_run = n_run; m_h12 = n_h12; m_flag = n_flag; m_trim = n_trim;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_tick = 0; m_busy = 0; m_adj = 0; m_pos = 0; m_run = 0;
            m_h12 = 0; m_flag = 0; m_trim = 0; m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0;
        end else model_step();
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tick_1hz == m_tick[0], "R9 tick_1hz", tick_1hz, m_tick);
            check(irq == m_flag[0], "R10 irq", irq, m_flag);
            check(reg_busy == (m_busy != 0), "R8 reg_busy", reg_busy, m_busy != 0);
            if (tick_1hz) begin tick_iv = cyc - tick_at; tick_at = cyc; end
        end
    end

    function automatic int model_read(int a);
        case (a)
            0: return m_run | (m_h12 << 1) | (m_flag << 2) | ((m_busy != 0) << 3);
            1: return m_sec;
            2: return m_min;
            3: return (m_pm << 7) | m_hr;
            4: return m_trim;
            default: return 0;
        endcase
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d[7:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_now(int a, int d);
        bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d[7:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_lit(int a, int exp, string tag);
        @(negedge clk);
        bus_addr = a[2:0];
        #1;
        check(int'(bus_rdata) == exp, tag, bus_rdata, exp);
    endtask

    task automatic rd_mdl(int a, string tag);
        @(negedge clk);
        bus_addr = a[2:0];
        #1;
        check(int'(bus_rdata) == model_read(a), tag, bus_rdata, model_read(a));
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick_1hz);
        #1;
    endtask

    task automatic trim_iv(int code, int exp, string tag);
        wait_tick();
        wr(4, 8'h80 | code);
        wait_tick();
        check(tick_iv == exp, tag, tick_iv, exp);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int mark, s0, tk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        for (int a = 0; a < 8; a++) rd_lit(a, 0, "R13 reset register");
        check(!tick_1hz && !irq && !reg_busy, "R13 reset outputs", {tick_1hz, irq, reg_busy}, 0);

        // R1 R4 second/minute/hour rollover in 24h mode
        wr(1, 8'h58); wr(2, 8'h59); wr(3, 8'h23); wr(0, 8'h01);
        wait_tick(); rd_lit(1, 8'h59, "R1 sec 58->59");
        wait_tick();
        rd_lit(1, 8'h00, "R1 sec wrap");
        rd_lit(2, 8'h00, "R1 min wrap");
        rd_lit(3, 8'h00, "R4 hour 23->00");
        check(irq == 1'b1, "R10 flag set on wrap", irq, 1);
        rd_lit(0, 8'h05, "R10 CTRL flag bit");

        // R10 clear by writing 1, R3 restart timing
        wr(0, 8'h05);
        mark = cyc;
        check(irq == 1'b0, "R10 flag cleared", irq, 0);
        wait_tick();
        check(tick_at - mark == PER, "R3 first tick after restart", tick_at - mark, PER);
        wait_tick();
        check(tick_iv == PER, "R9 interval", tick_iv, PER);

        // R2 stop freezes, resume continues
        wr(0, 8'h00);
        rd_mdl(1, "R2 sec read stopped");
        s0 = m_sec; tk = 0;
        for (int i = 0; i < 3 * PER; i++) begin @(negedge clk); if (tick_1hz) tk++; end
        check(tk == 0, "R2 no tick while stopped", tk, 0);
        rd_lit(1, s0, "R2 sec held");
        wr(0, 8'h01);
        wait_tick();
        rd_lit(1, d2b(b2d(s0) + 1), "R2 resume from held");

        // R5 12h mode transitions
        wr(0, 8'h02); wr(1, 8'h59); wr(2, 8'h59); wr(3, 8'h11); wr(0, 8'h03);
        wait_tick(); rd_lit(3, 8'h92, "R5 11am->12pm");
        wr(0, 8'h02); wr(1, 8'h59); wr(2, 8'h59); wr(3, 8'h92); wr(0, 8'h03);
        wait_tick(); rd_lit(3, 8'h81, "R5 12pm->1pm");
        wr(0, 8'h02); wr(1, 8'h59); wr(2, 8'h59); wr(3, 8'h91); wr(0, 8'h03);
        wait_tick(); rd_lit(3, 8'h12, "R5 11pm->12am");
        rd_lit(2, 8'h00, "R1 minutes wrap in 12h");

        // R11 write in the advance cycle wins
        wr(0, 8'h04); wr(1, 8'h10); wr(0, 8'h01);
        wait_tick();
        wr_now(1, 8'h30);
        rd_lit(1, 8'h30, "R11 write beats advance");
        wait_tick(); rd_lit(1, 8'h31, "R11 next advance");

        // R6 R7 R8 rate regulation
        wait_tick(); wait_tick();
        wr(4, 8'h85);
        rd_lit(0, 8'h09, "R8 busy visible in CTRL");
        wr(4, 8'h80 | 54);
        rd_lit(4, 54, "R12 trim stored while busy");
        wait_tick();
        check(tick_iv == PER - 5, "R8 retrigger ignored, +5 kept", tick_iv, PER - 5);
        trim_iv(54, PER + 10, "R7 negative trim -10");
        trim_iv(32, PER - 32, "R6 code 32 = +32");
        trim_iv(33, PER + 31, "R6 code 33 = -31");
        trim_iv(0, PER, "R6 code 0 no change");
        trim_iv(1, PER - 1, "R7 positive trim +1");
        wait_tick();
        check(tick_iv == PER, "R7 later second unaffected", tick_iv, PER);
        rd_mdl(1, "R1 sec after trims");
        rd_mdl(0, "R12 CTRL after trims");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule